// File: doc/BRIEF.md
# Descriptor Ring Sequencer

This block walks a circular list of fixed-size DMA descriptors for a single channel. Software places the list in memory, programs its base address and its size, and sets a run bit. The block then visits the descriptors one after another. For each one it reads the status word and tests the ownership flag. If the flag is set, it passes the descriptor address to a data mover and waits until the mover reports completion. It then writes the status word back with the flag cleared and steps to the next slot. After the last slot it returns to the first.

There are two reasons to suspend. The first is a tail match: the current descriptor address is exactly equal to the programmed tail address. The second is an empty slot: the descriptor's ownership flag is clear, which means no buffer is available. Each reason sets its own sticky interrupt bit. A write to the tail register is a poll demand and wakes a suspended engine. When that write arrives while the engine is busy, it is held until the engine next suspends. Because the tail is an absolute address, a value that no slot can take turns tail stopping off completely. Only the flag in each descriptor decides ownership.

Top module: `dring_ctl`

## Requirements
- R1: After reset, status reads 0 (stopped), both interrupt bits are 0, and mem_req and mv_valid are low.
- R2: A write to select 3 with bit 0 set while stopped reloads cur_ptr from the base (select 0). Status then reads 1 (running) from the next cycle on.
- R3: For each visit the block reads the address cur_ptr+12. Bit 31 of that word is the ownership flag. When the flag is set, the block raises mv_valid with mv_desc equal to cur_ptr. After mv_done, it writes the same word back to cur_ptr+12 with bit 31 cleared and every other bit kept.
- R4: Descriptors are 16 bytes apart. The length register (select 1) holds the count minus one, so all N slots are used. After completing slot N-1 the block returns to the base.
- R5: Just before a fetch, if cur_ptr equals the tail (select 2), the block suspends with status 2 and sets irq_tail. A tail that matches no slot address, whether above or below the ring, never causes a stop.
- R6: A fetched word with bit 31 clear suspends the block with status 3 and sets irq_unavail. There is no hand-off, no write-back and no advance.
- R7: A tail write wakes either kind of suspension and the slot is tested again. The exception is a newly written tail equal to cur_ptr: then the block stays suspended.
- R8: A tail write that arrives while the block is running is remembered. The block resumes once at its next suspension.
- R9: Writing select 4 clears irq_tail with bit 0 and irq_unavail with bit 1. Each bit is cleared by writing 1.
- R10: Writing select 3 with bit 0 clear stops the block (status 0) at its next tail test or while suspended. Tail writes made while stopped do not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 base, 1 length, 2 tail, 3 control, 4 interrupt clear |
| cfg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for write-back, 0 for status fetch |
| mem_addr | output | AW | Byte address of the descriptor status word |
| mem_wdata | output | DW | Status word written back |
| mem_ack | input | 1 | Memory completion strobe |
| mem_rdata | input | DW | Fetched status word, valid with mem_ack |
| mv_valid | output | 1 | Descriptor handed to the data mover |
| mv_desc | output | AW | Address of the handed descriptor |
| mv_done | input | 1 | Data mover finished the descriptor |
| status | output | 2 | 0 stopped, 1 running, 2 suspended on tail, 3 suspended on empty slot |
| cur_ptr | output | AW | Current descriptor address |
| irq_tail | output | 1 | Sticky tail-stop interrupt |
| irq_unavail | output | 1 | Sticky empty-slot interrupt |

## Verification
The hardest case to reach is a poll demand that lands while the engine is busy. From the ports, such a write is indistinguishable from one made during suspension unless the engine reaches a suspension later. The bench stalls the data mover on the first slot and writes the tail during that stall. It then releases the mover and lets the engine run into an empty slot. The remembered demand shows up as a second status fetch of that same slot, which the bench memory model counts. Ring sizes from one to four are swept, and every tail position inside each ring is tried as well as positions below and above it.

// File: rtl/dring_pkg.sv
package dring_pkg;

  typedef enum logic [1:0] {
    ST_STOPPED   = 2'd0,
    ST_RUNNING   = 2'd1,
    ST_SUSP_TAIL = 2'd2,
    ST_SUSP_UNAV = 2'd3
  } dr_status_e;

  typedef enum logic [2:0] {
    F_STOP,
    F_CHECK,
    F_FETCH,
    F_HAND,
    F_WB,
    F_SUSP_TAIL,
    F_SUSP_UNAV
  } dr_fsm_e;

  localparam logic [2:0] SEL_BASE = 3'd0;
  localparam logic [2:0] SEL_LEN  = 3'd1;
  localparam logic [2:0] SEL_TAIL = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_IRQ  = 3'd4;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          set_tail_irq,
  input  logic          set_unav_irq,
  output logic [AW-1:0] base_q,
  output logic [IW-1:0] len_q,
  output logic [AW-1:0] tail_q,
  output logic          run_q,
  output logic          start_pulse,
  output logic          tail_wr,
  output logic          irq_tail,
  output logic          irq_unav
);

  logic clr_wr;

  assign start_pulse = we && (sel == SEL_CTRL) && wdata[0];
  assign tail_wr     = we && (sel == SEL_TAIL);
  assign clr_wr      = we && (sel == SEL_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      tail_q <= '0;
      run_q  <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_BASE: base_q <= wdata;
        SEL_LEN:  len_q  <= wdata[IW-1:0];
        SEL_TAIL: tail_q <= wdata;
        SEL_CTRL: run_q  <= wdata[0];
        default:  ;
      endcase
    end
  end

  // a new suspension event takes precedence over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tail <= 1'b0;
      irq_unav <= 1'b0;
    end else begin
      if (set_tail_irq)           irq_tail <= 1'b1;
      else if (clr_wr && wdata[0]) irq_tail <= 1'b0;
      if (set_unav_irq)           irq_unav <= 1'b1;
      else if (clr_wr && wdata[1]) irq_unav <= 1'b0;
    end
  end

endmodule

// File: rtl/dring_walk.sv
module dring_walk #(
  parameter int AW        = 32,
  parameter int IW        = 8,
  parameter int LOG2_DESC = 4,
  parameter int STAT_WORD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] len,
  output logic [IW-1:0] idx,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] stat_addr
);

  localparam int STAT_OFS = STAT_WORD * 4;

  function automatic logic [AW-1:0] f_desc_addr(input logic [AW-1:0] b, input logic [IW-1:0] i);
    return b + (AW'(i) << LOG2_DESC);
  endfunction

  function automatic logic [IW-1:0] f_next_idx(input logic [IW-1:0] i, input logic [IW-1:0] last);
    return (i == last) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (load)  idx <= '0;
    else if (step)  idx <= f_next_idx(idx, len);
  end

  assign cur_ptr   = f_desc_addr(base, idx);
  assign stat_addr = cur_ptr + AW'(STAT_OFS);

endmodule

// File: rtl/dring_fsm.sv
module dring_fsm
  import dring_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int OWN_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_pulse,
  input  logic          run_q,
  input  logic          tail_wr,
  input  logic [AW-1:0] cur_ptr,
  input  logic [AW-1:0] tail_q,
  input  logic [AW-1:0] stat_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mv_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mv_valid,
  output logic [AW-1:0] mv_desc,
  output logic          load,
  output logic          step,
  output logic          ev_tail_hit,
  output logic          ev_unavail,
  output logic          ev_resume,
  output logic [1:0]    status
);

  localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_BIT;

  dr_fsm_e       state, nxt;
  logic [DW-1:0] word_q;
  logic          pend;
  logic          in_susp;
  logic          ev_owned;

  assign in_susp     = (state == F_SUSP_TAIL) || (state == F_SUSP_UNAV);
  assign ev_tail_hit = (state == F_CHECK) && run_q && (cur_ptr == tail_q);
  assign ev_owned    = (state == F_FETCH) && mem_ack && mem_rdata[OWN_BIT];
  assign ev_unavail  = (state == F_FETCH) && mem_ack && !mem_rdata[OWN_BIT];
  assign ev_resume   = in_susp && run_q && pend && (tail_q != cur_ptr);
  assign load        = (state == F_STOP) && start_pulse;
  assign step        = (state == F_WB) && mem_ack;

  assign mem_req   = (state == F_FETCH) || (state == F_WB);
  assign mem_we    = (state == F_WB);
  assign mem_addr  = stat_addr;
  assign mem_wdata = word_q & ~OWN_MASK;
  assign mv_valid  = (state == F_HAND);
  assign mv_desc   = cur_ptr;

  always_comb begin
    case (state)
      F_STOP:      status = ST_STOPPED;
      F_SUSP_TAIL: status = ST_SUSP_TAIL;
      F_SUSP_UNAV: status = ST_SUSP_UNAV;
      default:     status = ST_RUNNING;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      F_STOP:  if (load) nxt = F_CHECK;
      F_CHECK: begin
        if (!run_q)           nxt = F_STOP;
        else if (ev_tail_hit) nxt = F_SUSP_TAIL;
        else                  nxt = F_FETCH;
      end
      F_FETCH: begin
        if (ev_owned)        nxt = F_HAND;
        else if (ev_unavail) nxt = F_SUSP_UNAV;
      end
      F_HAND:  if (mv_done) nxt = F_WB;
      F_WB:    if (mem_ack) nxt = F_CHECK;
      F_SUSP_TAIL, F_SUSP_UNAV: begin
        if (!run_q)         nxt = F_STOP;
        else if (ev_resume) nxt = F_CHECK;
      end
      default: nxt = F_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= F_STOP;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (ev_owned) word_q <= mem_rdata;
  end

  // poll demand latch: a suspended state consumes it, a busy state accumulates it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (state == F_STOP)  pend <= 1'b0;
    else if (in_susp)          pend <= tail_wr;
    else                       pend <= pend | tail_wr;
  end

endmodule

// File: rtl/dring_ctl.sv
module dring_ctl
  import dring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int IW        = 8,
  parameter int LOG2_DESC = 4,
  parameter int STAT_WORD = 3,
  parameter int OWN_BIT   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mv_valid,
  output logic [AW-1:0] mv_desc,
  input  logic          mv_done,
  output logic [1:0]    status,
  output logic [AW-1:0] cur_ptr,
  output logic          irq_tail,
  output logic          irq_unavail
);

  logic [AW-1:0] base_q, tail_q, stat_addr;
  logic [IW-1:0] len_q, idx;
  logic          run_q, start_pulse, tail_wr;
  logic          load, step;
  logic          ev_tail_hit, ev_unavail, ev_resume;

  dring_regs #(.AW(AW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .set_tail_irq(ev_tail_hit), .set_unav_irq(ev_unavail),
    .base_q(base_q), .len_q(len_q), .tail_q(tail_q), .run_q(run_q),
    .start_pulse(start_pulse), .tail_wr(tail_wr),
    .irq_tail(irq_tail), .irq_unav(irq_unavail)
  );

  dring_walk #(.AW(AW), .IW(IW), .LOG2_DESC(LOG2_DESC), .STAT_WORD(STAT_WORD)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base(base_q), .len(len_q), .idx(idx), .cur_ptr(cur_ptr), .stat_addr(stat_addr)
  );

  dring_fsm #(.AW(AW), .DW(DW), .OWN_BIT(OWN_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .run_q(run_q), .tail_wr(tail_wr),
    .cur_ptr(cur_ptr), .tail_q(tail_q), .stat_addr(stat_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mv_done(mv_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mv_valid(mv_valid), .mv_desc(mv_desc), .load(load), .step(step),
    .ev_tail_hit(ev_tail_hit), .ev_unavail(ev_unavail), .ev_resume(ev_resume),
    .status(status)
  );

endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int IW      = 8,
  parameter int OWN_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          mv_valid,
  input logic [1:0]    status,
  input logic [AW-1:0] cur_ptr,
  input logic [AW-1:0] tail_q,
  input logic          run_q,
  input logic [IW-1:0] idx,
  input logic [IW-1:0] len_q,
  input logic          irq_tail,
  input logic          irq_unavail,
  input logic          load,
  input logic          step,
  input logic          ev_tail_hit,
  input logic          ev_unavail
);

  a_r2_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (status == 2'd1) && (idx == '0));

  a_r3_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> !mem_req);

  a_r4_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (idx == len_q)) |=> (idx == '0));

  a_r5_tail_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tail_hit |=> irq_tail && (status == 2'd2));

  a_r6_unavail_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |=> irq_unavail && (status == 2'd3));

  a_r7_equal_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && run_q && (tail_q == cur_ptr)) |=> (status == $past(status)));

endmodule

bind dring_ctl dring_chk #(.AW(AW), .DW(DW), .IW(IW), .OWN_BIT(OWN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .mv_valid(mv_valid), .status(status), .cur_ptr(cur_ptr), .tail_q(tail_q), .run_q(run_q),
  .idx(idx), .len_q(len_q), .irq_tail(irq_tail), .irq_unavail(irq_unavail),
  .load(load), .step(step), .ev_tail_hit(ev_tail_hit), .ev_unavail(ev_unavail)
);

// File: tb/sim_dring_ctl.sv
module sim_dring_ctl;

  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h0000_2000;
  localparam logic [31:0] OWN  = 32'h8000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req, mem_we, mv_valid, irq_tail, irq_unavail;
  logic [31:0] mem_addr, mem_wdata, mv_desc, cur_ptr;
  logic        mem_ack = 1'b0, mv_done = 1'b0, mv_stall = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  status;

  logic [31:0] smem [0:7];
  int          rcnt [0:7];
  logic [31:0] hlog [0:63];
  int          hcnt = 0, bad_addr = 0;
  int          checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dring_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mv_valid(mv_valid), .mv_desc(mv_desc),
    .mv_done(mv_done), .status(status), .cur_ptr(cur_ptr),
    .irq_tail(irq_tail), .irq_unavail(irq_unavail)
  );

  // memory and data-mover models, answering one cycle after a request
  always @(negedge clk) begin : resp
    logic [31:0] ofs;
    int k;
    if (mem_req && !mem_ack) begin
      ofs = mem_addr - BASE;
      k = int'(ofs >> 4);
      if (ofs[3:0] != 4'd12 || ofs >= 32'd128) bad_addr++;
      else if (mem_we) smem[k] = mem_wdata;
      else begin mem_rdata = smem[k]; rcnt[k]++; end
      mem_ack = 1'b1;
    end else mem_ack = 1'b0;
    if (mv_valid && !mv_done && !mv_stall) begin
      if (hcnt < 64) hlog[hcnt] = mv_desc;
      hcnt++;
      mv_done = 1'b1;
    end else mv_done = 1'b0;
  end

  function automatic logic [31:0] pat(input int k);
    return 32'h0000_0A05 + 32'(k) * 32'h0001_1100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_status(input logic [1:0] code, input string req);
    int n = 0;
    while (status != code && n < 3000) begin @(negedge clk); n++; end
    chk(status == code, req, 32'(status), 32'(code));
  endtask

  task automatic own_all(input int n);
    for (int k = 0; k < 8; k++) begin
      smem[k] = (k < n) ? (OWN | pat(k)) : pat(k);
      rcnt[k] = 0;
    end
    hcnt = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    own_all(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 2'd0, "R1 status", 32'(status), 0);
    chk(!irq_tail && !irq_unavail, "R1 irq", {30'd0, irq_tail, irq_unavail}, 0);
    chk(!mem_req && !mv_valid, "R1 idle ports", {30'd0, mem_req, mv_valid}, 0);

    for (int n = 1; n <= 4; n++) begin
      bit ok;
      int tot;
      // full pass with tail below the ring: R2 R3 R4 R5 R6
      own_all(n);
      wr(3'd0, BASE);
      wr(3'd1, 32'(n - 1));
      wr(3'd2, BASE - 32'd16);
      wr(3'd4, 32'd3);
      wr(3'd3, 32'd1);
      chk(cur_ptr == BASE && status == 2'd1, "R2 start reload", cur_ptr, BASE);
      wait_status(2'd3, "R6 empty slot suspend");
      chk(hcnt == n, "R5 tail outside ring never stops", 32'(hcnt), 32'(n));
      ok = 1'b1;
      for (int k = 0; k < n; k++) if (hlog[k] != BASE + 32'(16 * k)) ok = 1'b0;
      chk(ok, "R4 16-byte stride order", 32'(ok), 1);
      ok = 1'b1;
      for (int k = 0; k < n; k++) if (smem[k] != pat(k)) ok = 1'b0;
      chk(ok, "R3 write-back clears flag only", 32'(ok), 1);
      tot = 0;
      for (int k = 0; k < 8; k++) tot += rcnt[k];
      chk(tot == n + 1 && rcnt[0] == 2, "R6 no advance on empty slot", 32'(tot), 32'(n + 1));
      chk(cur_ptr == BASE, "R4 wrap to base", cur_ptr, BASE);
      chk(irq_unavail && !irq_tail, "R6 irq", {30'd0, irq_tail, irq_unavail}, 1);

      // wake from empty-slot suspension: R7
      own_all(n);
      wr(3'd2, 32'hFFFF_FFF0);
      repeat (3) @(negedge clk);
      wait_status(2'd3, "R7 resume then empty again");
      chk(hcnt == n, "R7 resumed pass", 32'(hcnt), 32'(n));

      wr(3'd4, 32'd2);
      chk(!irq_unavail, "R9 clear unavail", 32'(irq_unavail), 0);
      wr(3'd3, 32'd0);
      @(negedge clk);
      chk(status == 2'd0, "R10 stop from suspend", 32'(status), 0);

      // every tail position inside the ring: R5 R7 R9
      for (int t = 0; t < n; t++) begin
        own_all(n);
        wr(3'd2, BASE + 32'(16 * t));
        wr(3'd3, 32'd1);
        wait_status(2'd2, "R5 tail stop");
        chk(hcnt == t && cur_ptr == BASE + 32'(16 * t), "R5 stop position", cur_ptr, BASE + 32'(16 * t));
        chk(irq_tail, "R5 irq", 32'(irq_tail), 1);
        wr(3'd2, BASE + 32'(16 * t));
        repeat (4) @(negedge clk);
        chk(status == 2'd2 && hcnt == t, "R7 equal tail no restart", 32'(status), 2);
        wr(3'd2, BASE + 32'h100);
        repeat (2) @(negedge clk);
        wait_status(2'd3, "R7 tail wake");
        chk(hcnt == n, "R7 remaining slots done", 32'(hcnt), 32'(n));
        wr(3'd4, 32'd1);
        chk(!irq_tail && irq_unavail, "R9 clear tail only", {30'd0, irq_tail, irq_unavail}, 1);
        wr(3'd4, 32'd2);
        wr(3'd3, 32'd0);
        @(negedge clk);
      end
    end

    // poll demand while busy is remembered: R8
    own_all(1);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'hFFFF_FFF0);
    mv_stall = 1'b1;
    wr(3'd3, 32'd1);
    while (!mv_valid) @(negedge clk);
    wr(3'd2, 32'hFFFF_FFE0);
    mv_stall = 1'b0;
    wait_status(2'd3, "R8 suspend");
    repeat (10) @(negedge clk);
    chk(rcnt[1] == 2, "R8 remembered poll refetch", 32'(rcnt[1]), 2);
    chk(status == 2'd3, "R8 settles suspended", 32'(status), 3);

    // R10 stop then tail write while stopped
    wr(3'd3, 32'd0);
    @(negedge clk);
    wr(3'd2, 32'hFFFF_FF00);
    repeat (4) @(negedge clk);
    chk(status == 2'd0 && !mem_req, "R10 tail write while stopped", 32'(status), 0);
    chk(bad_addr == 0, "R3 status word address", 32'(bad_addr), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule